// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a stereo pair of 24-bit samples out on one serial data line. A word-select line frames the data, and a bit clock times each bit. A host loads a left/right pair at any time with a one-cycle strobe. The block takes that pair into use only when a new frame begins. It then shifts each channel out MSB first in a 32-bit slot and pads the rest of the slot with zeros.

Two framing conventions share the same shifter:
- In I2S framing, the first data bit comes one bit period after word-select changes.
- In MSB-justified framing, the first data bit comes in the same bit period as the change.

The block can also work in either of two clocking roles:
- As master, it derives the bit clock and word-select from a system clock that runs at 256 times the sample rate.
- As slave, it samples both lines from pins through a synchroniser and drives only the data line.

Top module: `audtx_top`

## Requirements
- R1: In master mode `bck_out` is the system clock divided by 4. It is high for 2 clock cycles and low for 2 clock cycles, and `link_drive` is 1.
- R2: In master mode `ws_out` changes only on a falling edge of `bck_out`, and it holds each level for 32 bit-clock periods. Level 0 is the left slot and level 1 is the right slot.
- R3: In I2S framing, the bit sampled on the bit-clock rise right after a word-select change is 0. The 24 sample bits follow, MSB first.
- R4: In MSB-justified framing, the sample MSB is on the line in the bit period where word-select changes. The remaining 23 bits follow.
- R5: `sd_out` changes only on a falling bit-clock edge. Every slot bit outside the 24 sample bits is 0.
- R6: In slave mode `link_drive`, `bck_out` and `ws_out` are 0. `sd_out` follows the external `bck_in`/`ws_in` in both framings.
- R7: Selects are coded 2'b00 = low, 2'b10 = high, and 2'b01 or 2'b11 = middle. A middle-level `role_sel` acts as slave (low), and a middle-level `fmt_sel` acts as I2S (low). High selects master and MSB-justified respectively.
- R8: A pair loaded during a frame first appears in the next left slot. The current frame's remaining slot still carries the previous pair.
- R9: While reset is held in master mode, `bck_out` is 0, `ws_out` is 1 and `sd_out` is 0. The first slot after reset is a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_sel | input | 2 | Clock role, three-level code (high = master) |
| fmt_sel | input | 2 | Framing, three-level code (high = MSB-justified) |
| smp_l | input | 24 | Left sample |
| smp_r | input | 24 | Right sample |
| smp_load | input | 1 | One-cycle strobe that captures the sample pair |
| bck_in | input | 1 | External bit clock, used in slave mode |
| ws_in | input | 1 | External word select, used in slave mode |
| bck_out | output | 1 | Generated bit clock (0 in slave mode) |
| ws_out | output | 1 | Generated word select (0 in slave mode) |
| link_drive | output | 1 | 1 when the clock lines should be driven |
| sd_out | output | 1 | Serial data |

## Verification
The hardest state to reach from the ports is a load that lands in the middle of a left slot. At that moment the old right sample is still owed, and the new left sample must wait for the next frame boundary. The bench watches the left word arrive through its own receiver and pulses the load strobe right after it. It then checks the next three words in order. A second hard case is the slave path, where data must stay aligned with edges seen through a synchroniser. The bench drives its own bit clock at 8 system clocks per bit and decodes the words with an independent receiver model for each framing.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    // Three-level select pins arrive pre-coded on two bits.
    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    // Only a clean high level selects master; middle/reserved fall back to slave.
    function automatic logic sel_is_master(input logic [1:0] lvl);
        return (lvl == LVL_HIGH);
    endfunction

    // Only a clean high level selects MSB-justified; middle/reserved fall back to I2S.
    function automatic logic sel_is_msbj(input logic [1:0] lvl);
        return (lvl == LVL_HIGH);
    endfunction

endpackage

// File: rtl/audtx_master_clk.sv
module audtx_master_clk #(
    parameter int CLK_PER_BCK = 4,
    parameter int SLOT_BITS   = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic bck_o,
    output logic ws_o,
    output logic fall_o,
    output logic ws_next_o
);
    localparam int DIV_W = (CLK_PER_BCK > 2) ? $clog2(CLK_PER_BCK) : 1;
    localparam int POS_W = $clog2(2 * SLOT_BITS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_BCK - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_PER_BCK / 2);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] pos;
        logic             bck;
        logic             ws;
    } gen_t;

    gen_t gen_q, gen_d;
    logic fall;

    always_comb begin
        gen_d = gen_q;
        fall  = (gen_q.div == DIV_LAST);
        if (fall) begin
            gen_d.div = '0;
            gen_d.pos = gen_q.pos + 1'b1;
            gen_d.ws  = gen_d.pos[POS_W-1];
        end else begin
            gen_d.div = gen_q.div + 1'b1;
        end
        gen_d.bck = (gen_d.div >= DIV_HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{div: '0, pos: '1, bck: 1'b0, ws: 1'b1};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign bck_o     = gen_q.bck;
    assign ws_o      = gen_q.ws;
    assign fall_o    = fall;
    assign ws_next_o = gen_d.ws;

    // R1: the bit clock only drops on the divider's wrap strobe
    a_r1_bck_fall_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gen_q.bck) |-> $past(fall));

    // R2: word select only moves together with a falling bit clock
    a_r2_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gen_q.ws) |-> $fell(gen_q.bck));

endmodule

// File: rtl/audtx_slave_track.sv
module audtx_slave_track #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    output logic fall_o,
    output logic ws_o
);
    localparam int BW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [BW-1:0]          bck_sh;
        logic [SYNC_STAGES-1:0] ws_sh;
    } trk_t;

    trk_t trk_q, trk_d;

    always_comb begin
        trk_d        = trk_q;
        trk_d.bck_sh = {trk_q.bck_sh[BW-2:0], bck_i};
        if (SYNC_STAGES > 1) begin
            trk_d.ws_sh = {trk_q.ws_sh[SYNC_STAGES-2:0], ws_i};
        end else begin
            trk_d.ws_sh = SYNC_STAGES'(ws_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{bck_sh: '1, ws_sh: '1};
        end else begin
            trk_q <= trk_d;
        end
    end

    // A falling edge is seen once the settled bit drops below the older one.
    assign fall_o = trk_q.bck_sh[BW-1] & ~trk_q.bck_sh[BW-2];
    assign ws_o   = trk_q.ws_sh[SYNC_STAGES-1];

endmodule

// File: rtl/audtx_shifter.sv
module audtx_shifter #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_i,
    input  logic                ws_i,
    input  logic                msbj_i,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] l_i,
    input  logic [SAMPLE_W-1:0] r_i,
    output logic                sd_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] act_l;
        logic [SAMPLE_W-1:0] act_r;
        logic [SAMPLE_W-1:0] sh;
        logic                ws_prev;
        logic                sd;
    } sft_t;

    sft_t sft_q, sft_d;
    logic                slot_start;
    logic                left_start;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        sft_d      = sft_q;
        slot_start = ev_i && (ws_i != sft_q.ws_prev);
        left_start = slot_start && !ws_i;
        word       = ws_i ? sft_q.act_r : sft_q.hold_l;
        if (load_i) begin
            sft_d.hold_l = l_i;
            sft_d.hold_r = r_i;
        end
        if (ev_i) begin
            sft_d.ws_prev = ws_i;
            if (slot_start) begin
                if (left_start) begin
                    sft_d.act_l = sft_q.hold_l;
                    sft_d.act_r = sft_q.hold_r;
                end
                if (msbj_i) begin
                    sft_d.sd = word[SAMPLE_W-1];
                    sft_d.sh = {word[SAMPLE_W-2:0], 1'b0};
                end else begin
                    sft_d.sd = 1'b0;
                    sft_d.sh = word;
                end
            end else begin
                sft_d.sd = sft_q.sh[SAMPLE_W-1];
                sft_d.sh = {sft_q.sh[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sft_q <= '{hold_l: '0, hold_r: '0, act_l: '0, act_r: '0,
                       sh: '0, ws_prev: 1'b1, sd: 1'b0};
        end else begin
            sft_q <= sft_d;
        end
    end

    assign sd_o = sft_q.sd;

    // R8: the active pair only changes at a left-slot start
    a_r8_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sft_q.act_l) || !$stable(sft_q.act_r)) |->
            $past(ev_i && !ws_i && sft_q.ws_prev));

    // R3: I2S puts a zero in the bit period of the word-select change
    a_r3_i2s_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !msbj_i && (ws_i != sft_q.ws_prev)) |=> (sft_q.sd == 1'b0));

    // R4: MSB-justified puts the held left MSB out at the left-slot start
    a_r4_msbj_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && msbj_i && !ws_i && sft_q.ws_prev) |=>
            (sft_q.sd == $past(sft_q.hold_l[SAMPLE_W-1])));

endmodule

// File: rtl/audtx_top.sv
module audtx_top #(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_BITS   = 32,
    parameter int CLK_PER_BCK = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          role_sel,
    input  logic [1:0]          fmt_sel,
    input  logic [SAMPLE_W-1:0] smp_l,
    input  logic [SAMPLE_W-1:0] smp_r,
    input  logic                smp_load,
    input  logic                bck_in,
    input  logic                ws_in,
    output logic                bck_out,
    output logic                ws_out,
    output logic                link_drive,
    output logic                sd_out
);
    import audtx_pkg::*;

    logic is_master, is_msbj;
    logic m_bck, m_ws, m_fall, m_ws_next;
    logic s_fall, s_ws;
    logic ev_sel, ws_sel;

    assign is_master = sel_is_master(role_sel);
    assign is_msbj   = sel_is_msbj(fmt_sel);

    audtx_master_clk #(
        .CLK_PER_BCK(CLK_PER_BCK),
        .SLOT_BITS  (SLOT_BITS)
    ) i_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_o    (m_bck),
        .ws_o     (m_ws),
        .fall_o   (m_fall),
        .ws_next_o(m_ws_next)
    );

    audtx_slave_track #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_strk (
        .clk   (clk),
        .rst_n (rst_n),
        .bck_i (bck_in),
        .ws_i  (ws_in),
        .fall_o(s_fall),
        .ws_o  (s_ws)
    );

    assign ev_sel = is_master ? m_fall    : s_fall;
    assign ws_sel = is_master ? m_ws_next : s_ws;

    audtx_shifter #(
        .SAMPLE_W(SAMPLE_W)
    ) i_sft (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev_sel),
        .ws_i  (ws_sel),
        .msbj_i(is_msbj),
        .load_i(smp_load),
        .l_i   (smp_l),
        .r_i   (smp_r),
        .sd_o  (sd_out)
    );

    assign bck_out    = is_master ? m_bck : 1'b0;
    assign ws_out     = is_master ? m_ws  : 1'b0;
    assign link_drive = is_master;

    // R5: serial data only moves on a selected falling-edge event
    a_r5_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_out != $past(sd_out)) |-> $past(ev_sel));

    // R1: in master mode a high bit-clock phase lasts two cycles
    a_r1_bck_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && $stable(role_sel) && $fell(bck_out)) |-> $past(bck_out, 2));

endmodule

// File: tb/test_audtx_top.sv
`timescale 1ns/1ps
module test_audtx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  role_sel = 2'b10;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] smp_l = '0, smp_r = '0;
    logic        smp_load = 1'b0;
    logic        bck_in, ws_in;
    logic        bck_out, ws_out, link_drive, sd_out;

    always #10 clk = ~clk;

    audtx_top i_audtx_top (
        .clk(clk), .rst_n(rst_n), .role_sel(role_sel), .fmt_sel(fmt_sel),
        .smp_l(smp_l), .smp_r(smp_r), .smp_load(smp_load),
        .bck_in(bck_in), .ws_in(ws_in), .bck_out(bck_out), .ws_out(ws_out),
        .link_drive(link_drive), .sd_out(sd_out)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- external clock source (slave tests) ----------------
    bit       slave_run = 0;
    logic [8:0] sph = 9'h1FF;
    initial begin
        bck_in = 1'b1;
        ws_in  = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (slave_run) sph = sph + 1'b1;
            else           sph = 9'h1FF;
            bck_in = sph[2];
            ws_in  = sph[8];
        end
    end

    // ---------------- receiver model ----------------
    int   clr_epoch = 0, seen_epoch = 0;
    bit   mon_ext = 0, mon_master = 1;
    int   delay = 1;
    logic ob, ow, bck_last, ws_last, sd_last;
    bit   started, run_valid;
    int   k, run, v1, v2, v5, vz, nl, nr;
    logic [23:0] acc;
    logic [23:0] rxl [16];
    logic [23:0] rxr [16];

    always @(negedge clk) begin
        ob = mon_ext ? bck_in : bck_out;
        ow = mon_ext ? ws_in  : ws_out;
        if (seen_epoch != clr_epoch) begin
            seen_epoch = clr_epoch;
            started = 0; run_valid = 0; k = 0; run = 0;
            v1 = 0; v2 = 0; v5 = 0; vz = 0; nl = 0; nr = 0;
            ws_last = 1'b1; acc = '0;
        end
        if (rst_n) begin
            if (mon_master) begin
                if (ob != bck_last) begin
                    if (run_valid && run != 2) v1++;
                    run_valid = 1; run = 1;
                end else run++;
                if (sd_out != sd_last && !(bck_last && !ob)) v5++;
            end
            if (ob && !bck_last) begin
                if (ow != ws_last) begin
                    if (mon_master && started && k != 31) v2++;
                    started = 1; k = 0;
                end else k++;
                ws_last = ow;
                if (started) begin
                    if (k >= delay && k < delay + 24) begin
                        acc = {acc[22:0], sd_out};
                        if (k == delay + 23) begin
                            if (ow) begin if (nr < 16) rxr[nr] = acc; nr++; end
                            else    begin if (nl < 16) rxl[nl] = acc; nl++; end
                        end
                    end else if (sd_out !== 1'b0) vz++;
                end
            end
        end
        bck_last = ob;
        sd_last  = sd_out;
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wait_words(input int wl, input int wr);
        int t = 0;
        while ((nl < wl || nr < wr) && t < 6000) begin step(); t++; end
    endtask

    task automatic start_case(input logic [1:0] role, input logic [1:0] fmt,
                              input logic [23:0] l, input logic [23:0] r);
        step();
        rst_n = 0; slave_run = 0; smp_load = 0;
        role_sel = role; fmt_sel = fmt;
        mon_ext    = (role != 2'b10);
        mon_master = (role == 2'b10);
        delay      = (fmt == 2'b10) ? 0 : 1;
        clr_epoch++;
        repeat (3) step();
        rst_n = 1;
        step();
        smp_l = l; smp_r = r; smp_load = 1; slave_run = mon_ext;
        step();
        smp_load = 0;
    endtask

    task automatic run_case(input logic [1:0] role, input logic [1:0] fmt,
                            input logic [23:0] l, input logic [23:0] r, input string tag);
        start_case(role, fmt, l, r);
        wait_words(2, 2);
        chk(nl >= 2 && rxl[0] == l, {tag, " left word"},  {24'h0, rxl[0]}, {24'h0, l});
        chk(nr >= 2 && rxr[0] == r, {tag, " right word"}, {24'h0, rxr[0]}, {24'h0, r});
        chk(rxl[1] == l, {tag, " left repeats"}, {24'h0, rxl[1]}, {24'h0, l});
        chk(vz == 0, "R5 padding bits zero", 48'(vz), 48'h0);
        if (role == 2'b10) begin
            chk(v1 == 0 && run_valid, "R1 bck 2 high 2 low", 48'(v1), 48'h0);
            chk(v2 == 0, "R2 ws 32 bits per slot", 48'(v2), 48'h0);
            chk(v5 == 0, "R5 sd moves on bck fall", 48'(v5), 48'h0);
            chk(link_drive == 1'b1, "R1 link_drive in master", 48'(link_drive), 48'h1);
        end else begin
            chk(link_drive == 0 && bck_out == 0 && ws_out == 0, "R6 slave lines idle",
                {45'h0, link_drive, bck_out, ws_out}, 48'h0);
        end
    endtask

    typedef struct packed {
        logic [1:0]  role;
        logic [1:0]  fmt;
        logic [23:0] l;
        logic [23:0] r;
        logic [31:0] tagid;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b10, 2'b00, 24'h800001, 24'h7FFFFE, 32'd3},
        '{2'b10, 2'b10, 24'hA5C3E1, 24'h000001, 32'd4},
        '{2'b00, 2'b00, 24'hFFFFFF, 24'h123456, 32'd6},
        '{2'b00, 2'b10, 24'h800000, 24'hFEDCBA, 32'd6},
        '{2'b01, 2'b01, 24'hC0FFEE, 24'h0F0F0F, 32'd7},
        '{2'b11, 2'b11, 24'h5A5A5A, 24'hA00005, 32'd7}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int il, ir;
        // R9: reset state in master mode
        repeat (2) step();
        chk(bck_out == 0 && ws_out == 1 && sd_out == 0, "R9 reset outputs",
            {45'h0, bck_out, ws_out, sd_out}, 48'b010);

        // table-driven: R3 I2S, R4 MSB-justified, R6 slave, R7 middle levels
        for (int i = 0; i < 6; i++) begin
            string tg;
            case (VEC[i].tagid)
                32'd3:   tg = "R3 i2s master";
                32'd4:   tg = "R4 msbj master";
                32'd6:   tg = "R6 slave";
                default: tg = "R7 middle level";
            endcase
            run_case(VEC[i].role, VEC[i].fmt, VEC[i].l, VEC[i].r, tg);
        end

        // R9: first slot after reset is left, carrying the first loaded word
        start_case(2'b10, 2'b10, 24'h111111, 24'h222222);
        wait_words(1, 0);
        chk(nr == 0 && rxl[0] == 24'h111111, "R9 first slot left",
            {24'h0, rxl[0]}, {24'h0, 24'h111111});

        // R8: load in the middle of a left slot
        wait_words(2, 1);
        il = nl; ir = nr;
        smp_l = 24'h3C3C3C; smp_r = 24'hC3C3C3; smp_load = 1;
        step();
        smp_load = 0;
        wait_words(il + 1, ir + 2);
        chk(rxr[ir] == 24'h222222, "R8 old right kept", {24'h0, rxr[ir]}, {24'h0, 24'h222222});
        chk(rxl[il] == 24'h3C3C3C, "R8 new left next frame", {24'h0, rxl[il]}, {24'h0, 24'h3C3C3C});
        chk(rxr[ir + 1] == 24'hC3C3C3, "R8 new right next frame", {24'h0, rxr[ir + 1]}, {24'h0, 24'hC3C3C3});

        // R9: reset again mid-stream returns to idle values
        rst_n = 0;
        step();
        chk(bck_out == 0 && ws_out == 1 && sd_out == 0, "R9 reset reapplied",
            {45'h0, bck_out, ws_out, sd_out}, 48'b010);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule